// File: doc/BRIEF.md
# Single-Word Interrupt Aggregator

This block collects a small group of level-type interrupt sources and merges them into one interrupt line toward a parent controller. Software sees it through one 32-bit word: the low half carries one enable bit per source, and the high half carries one sticky pending bit per source, always sixteen positions above the matching enable bit. A pending bit is captured whenever its source is high. It stays set after the source drops, until software writes a one to it.

Software services pending sources one at a time. It reads the word, handles a source whose pending and enable bits are both set, and writes back a word with that pending bit set to one. That write carries the current enables in the low half and zeros in every other pending position, so the enables are kept and no other pending bit is lost. The width of the source field and the position of its first bit are parameters.

Top module: `wordreg_irq_agg`

## Requirements
- R1: Enable bits sit at positions FIELD_LSB to FIELD_LSB+SRC_COUNT-1 of the word. Each full-word write loads them from the written data, and they read back unchanged until the next write.
- R2: The pending bit of source n sits at position FIELD_LSB+n+16, sixteen above that source's enable bit.
- R3: A pending bit sets on the clock edge where its source input is high. It stays set after the source input goes low.
- R4: A written 1 at a pending position clears that bit at the write's clock edge. A written 0 leaves the bit as it was.
- R5: If a source is high on the same edge as a write that clears its pending bit, the bit stays set.
- R6: Every bit outside the enable field and the pending field reads 0, and writes to it have no effect.
- R7: The read word shows every latched pending bit, whatever the state of its enable bit.
- R8: The parent output is a register. After each edge it equals the OR, over all sources, of (pending AND enable) as held before that edge. It therefore follows any change of state one clock later.
- R9: While reset is low, all enable bits, all pending bits and the parent output clear to 0 at the clock edge.
- R10: Clearing one serviced pending bit leaves other pending bits set, and the parent output stays high while any enabled source is still pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | SRC_COUNT | Level interrupt sources, bit n is source n |
| wr_en | input | 1 | Full-word write strobe for the control word |
| wr_data | input | 32 | Data written when wr_en is high |
| rd_data | output | 32 | Current control word: enables in the low half, pending bits in the high half |
| irq_o | output | 1 | Registered parent interrupt line |

## Verification
Pending and enable bits change at the same edge that samples the source or the write, so rd_data holds the new word one edge after the stimulus. The parent line passes through one more register and settles one edge after that. The bench drives every input on the falling edge. It reads rd_data at the first falling edge after the stimulus edge. It reads irq_o twice: once at that same falling edge, where it must still show the old value, and again one clock later, where it must show the new one. This tests the extra clock of latency as well as the final level.

// File: rtl/irq_agg_pkg.sv
// Package: shared constants and helpers for the single-word interrupt aggregator.
// Assumes a 32-bit control word split into two 16-bit halves.
package irq_agg_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    // Builds the mask of legal bit positions inside one half of the word.
    function automatic logic [HALF_W-1:0] half_mask(input int lsb, input int cnt);
        logic [HALF_W-1:0] m;
        m = '0;
        for (int p = 0; p < HALF_W; p++) begin
            if (p >= lsb && p < lsb + cnt) m[p] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_agg_enable_reg.sv
// Module: enable half of the control word.
// Holds one enable bit per source at its configured position. Positions
// outside the field are forced to zero, so writes to them have no effect.
// Assumes the caller passes the low half of the written word.
module irq_agg_enable_reg
    import irq_agg_pkg::*;
#(
    parameter int FIELD_LSB = 0,
    parameter int SRC_COUNT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wr_half,
    output logic [HALF_W-1:0] en_q
);

    localparam logic [HALF_W-1:0] FIELD_MASK = half_mask(FIELD_LSB, SRC_COUNT);

    // Load the enable field on a write; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= wr_half & FIELD_MASK;
        end
    end

endmodule

// File: rtl/irq_agg_pending_reg.sv
// Module: pending half of the control word.
// Each bit in the field is set by its level source and cleared by a
// written one. A source that is high wins over a clear on the same edge.
// Assumes the source vector is already shifted to the field position.
module irq_agg_pending_reg
    import irq_agg_pkg::*;
#(
    parameter int FIELD_LSB = 0,
    parameter int SRC_COUNT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] src_wide,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wr_half,
    output logic [HALF_W-1:0] pend_q
);

    localparam logic [HALF_W-1:0] FIELD_MASK = half_mask(FIELD_LSB, SRC_COUNT);

    logic [HALF_W-1:0] clr_vec;
    logic [HALF_W-1:0] pend_next;

    // Form the write-one-to-clear vector and the next pending state.
    always_comb begin
        clr_vec   = wr_en ? wr_half : '0;
        pend_next = ((pend_q & ~clr_vec) | src_wide) & FIELD_MASK;
    end

    // Register the pending bits; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_next;
        end
    end

endmodule

// File: rtl/irq_agg_parent.sv
// Module: parent interrupt generator.
// Registers the OR of all pending-and-enabled bits, so the line follows
// state changes one clock later and is free of glitches.
module irq_agg_parent
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] en_q,
    input  logic [HALF_W-1:0] pend_q,
    output logic              irq_q
);

    // Register the reduced request; reset drives it low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(en_q & pend_q);
        end
    end

endmodule

// File: rtl/wordreg_irq_agg.sv
// Module: single-word interrupt aggregator (top).
// Gathers SRC_COUNT level sources into one parent line. One 32-bit word
// holds enables (low half) and write-one-to-clear pending bits (high half,
// 16 above each enable). Assumes FIELD_LSB + SRC_COUNT <= 16.
module wordreg_irq_agg
    import irq_agg_pkg::*;
#(
    parameter int FIELD_LSB = 0,
    parameter int SRC_COUNT = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_COUNT-1:0] src_i,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 irq_o
);

    logic [HALF_W-1:0] src_wide;
    logic [HALF_W-1:0] en_q;
    logic [HALF_W-1:0] pend_q;

    // Place the source vector at the configured field position.
    always_comb begin
        src_wide = HALF_W'(src_i) << FIELD_LSB;
    end

    irq_agg_enable_reg #(
        .FIELD_LSB (FIELD_LSB),
        .SRC_COUNT (SRC_COUNT)
    ) en_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_half (wr_data[HALF_W-1:0]),
        .en_q    (en_q)
    );

    irq_agg_pending_reg #(
        .FIELD_LSB (FIELD_LSB),
        .SRC_COUNT (SRC_COUNT)
    ) pend_reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_wide (src_wide),
        .wr_en    (wr_en),
        .wr_half  (wr_data[WORD_W-1:HALF_W]),
        .pend_q   (pend_q)
    );

    irq_agg_parent parent_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_q   (en_q),
        .pend_q (pend_q),
        .irq_q  (irq_o)
    );

    // Assemble the read word from both halves.
    always_comb begin
        rd_data = {pend_q, en_q};
    end

endmodule

// File: rtl/irq_agg_chk.sv
// Checker: temporal properties of the single-word interrupt aggregator,
// observed only at its ports. Bound to every instance of the top module.
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int FIELD_LSB = 0,
    parameter int SRC_COUNT = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [SRC_COUNT-1:0] src_i,
    input logic                 wr_en,
    input logic [WORD_W-1:0]    wr_data,
    input logic [WORD_W-1:0]    rd_data,
    input logic                 irq_o
);

    localparam logic [HALF_W-1:0] FMASK = half_mask(FIELD_LSB, SRC_COUNT);
    localparam logic [WORD_W-1:0] LEGAL = {FMASK, FMASK};

    logic [HALF_W-1:0] rd_en;
    logic [HALF_W-1:0] rd_pend;
    logic [HALF_W-1:0] src_w;
    logic [HALF_W-1:0] wr_lo;

    // Split observed words into halves for the properties below.
    always_comb begin
        rd_en   = rd_data[HALF_W-1:0];
        rd_pend = rd_data[WORD_W-1:HALF_W];
        src_w   = HALF_W'(src_i) << FIELD_LSB;
        wr_lo   = wr_data[HALF_W-1:0];
    end

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~LEGAL) == '0);

    // R3
    src_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != '0) |=> ((rd_pend & $past(src_w)) == $past(src_w)));

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((rd_pend & $past(rd_pend)) == $past(rd_pend)));

    // R1
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_en));

    // R1
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_en == ($past(wr_lo) & FMASK)));

    // R8
    parent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(rd_pend & rd_en))));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !irq_o));

endmodule

bind wordreg_irq_agg irq_agg_chk #(
    .FIELD_LSB (FIELD_LSB),
    .SRC_COUNT (SRC_COUNT)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (src_i),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq_o   (irq_o)
);

// File: tb/wordreg_irq_agg_tb_top.sv
// Directed bench for the single-word interrupt aggregator, run with a
// shifted two-source field so offset mistakes show up.
module wordreg_irq_agg_tb_top;

    localparam int LSB  = 4;
    localparam int N    = 2;
    localparam int HALF = 16;
    localparam logic [31:0] EN0 = 32'(1) << LSB;
    localparam logic [31:0] EN1 = 32'(1) << (LSB + 1);
    localparam logic [31:0] PD0 = 32'(1) << (LSB + HALF);
    localparam logic [31:0] PD1 = 32'(1) << (LSB + 1 + HALF);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_i = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic          irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wordreg_irq_agg #(.FIELD_LSB(LSB), .SRC_COUNT(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic chk_word(input string tag, input logic [31:0] exp);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s: rd_data actual %h expected %h", tag, rd_data, exp);
        end
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        checks++;
        if (irq_o !== exp) begin
            errors++;
            $display("FAIL %s: irq_o actual %b expected %b", tag, irq_o, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic pulse_src(input logic [N-1:0] v);
        @(negedge clk);
        src_i = v;
        @(negedge clk);
        src_i = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_word("R9 word after reset", 32'h0);
        chk_irq("R9 irq after reset", 1'b0);
    endtask

    task automatic t_enable_field;
        bus_write(32'h0000_FFFF);
        chk_word("R1 R6 enable field only", EN0 | EN1);
        bus_write(EN0);
        chk_word("R1 single enable", EN0);
        bus_write(32'h0);
        chk_word("R1 enables cleared", 32'h0);
        chk_irq("R8 no request without pending", 1'b0);
    endtask

    task automatic t_latch;
        pulse_src(2'b01);
        chk_word("R2 R3 R7 pending at +16 while disabled", PD0);
        @(negedge clk);
        chk_word("R3 pending sticky after source low", PD0);
        chk_irq("R8 masked pending gives no irq", 1'b0);
    endtask

    task automatic t_enable_then_irq;
        bus_write(EN0);
        chk_word("R4 zero write keeps pending", PD0 | EN0);
        chk_irq("R8 irq still old right after enable", 1'b0);
        @(negedge clk);
        chk_irq("R8 irq one clock after enable", 1'b1);
    endtask

    task automatic t_service;
        bus_write(EN0 | EN1);
        pulse_src(2'b10);
        chk_word("R3 second source latched", PD0 | PD1 | EN0 | EN1);
        bus_write(EN0 | EN1 | PD0);
        chk_word("R4 R10 clear one keeps other", PD1 | EN0 | EN1);
        @(negedge clk);
        chk_irq("R10 irq held by remaining source", 1'b1);
    endtask

    task automatic t_set_wins;
        @(negedge clk);
        src_i = 2'b10;
        bus_write(EN0 | EN1 | PD1);
        chk_word("R5 set beats clear", PD1 | EN0 | EN1);
        src_i = '0;
        bus_write(EN0 | EN1 | PD1);
        chk_word("R4 clear with source low", EN0 | EN1);
        chk_irq("R8 irq still old after last clear", 1'b1);
        @(negedge clk);
        chk_irq("R8 irq drops one clock later", 1'b0);
    endtask

    task automatic t_outside;
        pulse_src(2'b01);
        bus_write(~(PD0 | PD1));
        chk_word("R6 outside bits ignored", PD0 | EN0 | EN1);
        @(negedge clk);
        chk_irq("R8 irq from enabled pending", 1'b1);
        bus_write(32'h0);
        chk_word("R7 pending kept when disabled", PD0);
        chk_irq("R8 irq still old after disable", 1'b1);
        @(negedge clk);
        chk_irq("R8 irq low after disable", 1'b0);
    endtask

    task automatic t_reset_busy;
        bus_write(EN0 | EN1);
        pulse_src(2'b11);
        @(negedge clk);
        chk_irq("R8 irq before reset", 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk_word("R9 word cleared by reset", 32'h0);
        chk_irq("R9 irq cleared by reset", 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_enable_field();
        t_latch();
        t_enable_then_irq();
        t_service();
        t_set_wins();
        t_outside();
        t_reset_busy();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule